// File: doc/BRIEF.md
# Recursive vertical-crosswise multiplier

This block is a purely combinational unsigned multiplier. It takes two 16-bit operands and returns their full 32-bit product. It has no clock and no handshake: the product follows the operands through logic alone.

The product is formed by recursive halving. Each operand is split into a high half and a low half. Four half-width multipliers of the same structure form the four cross products. Two carry-select adders then merge the shifted partial products. The recursion ends at a 2x2 cell that works in three steps. It multiplies the low bits directly, adds the two crosswise bit products at weight 2, and multiplies the high bits at weight 4.

The operand width is a parameter and must be a power of two, at least 2. The width of each carry-select block is also a parameter.

Top module: `vx_mul16`

## Requirements
- R1: For every pair of 16-bit unsigned operands, p_o equals a_i times b_i as a 32-bit unsigned value.
- R2: If either operand is zero, p_o is zero. If one operand is one, p_o equals the other operand zero-extended to 32 bits.
- R3: 0xFFFF times 0xFFFF gives 0xFFFE0001. At every level, the adder that merges the upper partial products never produces a carry out of its top bit.
- R4: With WIDTH set to 4 or to 8, every operand pair gives the exact 2*WIDTH-bit product.
- R5: With WIDTH set to 2, the base cell alone gives the exact 4-bit product for all 16 operand pairs. Bit 0 is a0&b0. Bit 1 is the XOR of the two crosswise terms a1&b0 and a0&b1. Bits 3:2 are a1&b1 plus the crosswise carry.
- R6: Each carry-select adder returns a+b+cin, including when a carry runs through every block. Operands 0x00FF, 0x0FFF, 0xFF00 and 0x8000 exercise such long carries.
- R7: The low 8 bits of p_o equal the low 8 bits of a_i[7:0] times b_i[7:0].
- R8: Swapping a_i and b_i leaves p_o unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | Multiplicand, unsigned |
| b_i | input | 16 | Multiplier, unsigned |
| p_o | output | 32 | Full unsigned product |

## Verification
The bench targets the following corner cases:

- **Base cell, all 16 pairs.** This pair is the only one that needs the carry between the two weight-4 terms. A cell that dropped that carry would give 5 instead of 9 for 3 times 3.
- **Merge adder overflow.** Full-scale operands make the merge adder's top bit active. A node that lost the carry out of the middle sum would show a missing 2^(N+N/2) term.
- **Long carry chains.** Operands such as 0x00FF and 0x0FFF send carries through every carry-select block. A wrong block select would corrupt one block's worth of bits.
- **Low-half pass-through.** The bench checks that the low half of the product is passed through unchanged.
- **Operand swap.** The bench checks that swapping the operands gives the same product. This catches cross products wired to the wrong weight.

// File: rtl/vx_pkg.sv
package vx_pkg;
  localparam int unsigned DEF_CSEL_BLK = 4;

  // width of carry-select block g in a w-bit adder split into blk-bit blocks
  function automatic int unsigned blk_width(int unsigned w, int unsigned blk, int unsigned g);
    int unsigned lo;
    lo = g * blk;
    return (w - lo < blk) ? (w - lo) : blk;
  endfunction
endpackage

// File: rtl/vx_cell2.sv
module vx_cell2 (
  input  logic [1:0] a_i,
  input  logic [1:0] b_i,
  output logic [3:0] p_o
);
  logic vert_lo, vert_hi, cross_a, cross_b, cross_c;

  assign vert_lo = a_i[0] & b_i[0];
  assign cross_a = a_i[1] & b_i[0];
  assign cross_b = a_i[0] & b_i[1];
  assign cross_c = cross_a & cross_b;
  assign vert_hi = a_i[1] & b_i[1];

  assign p_o[0] = vert_lo;
  assign p_o[1] = cross_a ^ cross_b;
  assign p_o[2] = vert_hi ^ cross_c;
  assign p_o[3] = vert_hi & cross_c;

  always_comb begin
    AST_CELL_EXACT: assert (p_o == 4'(a_i) * 4'(b_i)) else $error("cell2 product wrong"); // R5
  end
endmodule

// File: rtl/vx_csel_add.sv
module vx_csel_add #(
  parameter int unsigned W   = 8,
  parameter int unsigned BLK = vx_pkg::DEF_CSEL_BLK
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  localparam int unsigned NB = (W + BLK - 1) / BLK;

  logic [NB:0] carry;
  assign carry[0] = cin_i;

  for (genvar g = 0; g < NB; g++) begin : g_blk
    localparam int unsigned LO = g * BLK;
    localparam int unsigned BW = vx_pkg::blk_width(W, BLK, g);
    logic [BW:0] sum_c0, sum_c1;
    // both carry-in assumptions computed in parallel, chosen by the incoming carry
    assign sum_c0 = {1'b0, a_i[LO +: BW]} + {1'b0, b_i[LO +: BW]};
    assign sum_c1 = {1'b0, a_i[LO +: BW]} + {1'b0, b_i[LO +: BW]} + (BW+1)'(1);
    assign sum_o[LO +: BW] = carry[g] ? sum_c1[BW-1:0] : sum_c0[BW-1:0];
    assign carry[g+1]      = carry[g] ? sum_c1[BW]     : sum_c0[BW];
  end

  assign cout_o = carry[NB];

  always_comb begin
    AST_CSEL_SUM: assert ({cout_o, sum_o} == (W+1)'(a_i) + (W+1)'(b_i) + (W+1)'(cin_i))
      else $error("carry-select sum wrong"); // R6
  end
endmodule

// File: rtl/vx_node.sv
module vx_node #(
  parameter int unsigned W   = 16,
  parameter int unsigned BLK = vx_pkg::DEF_CSEL_BLK
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] p_o
);
  localparam int unsigned PW = 2 * W;

  if (W == 2) begin : g_base
    vx_cell2 u_cell (.a_i(a_i), .b_i(b_i), .p_o(p_o));
  end else begin : g_split
    localparam int unsigned HW = W / 2;
    localparam int unsigned UW = W + HW;

    logic [W-1:0]  pp_ll, pp_hl, pp_lh, pp_hh;
    logic [W-1:0]  mid_sum;
    logic          mid_cout;
    logic [UW-1:0] up_x, up_y, up_sum;
    logic          up_cout;

    vx_node #(.W(HW), .BLK(BLK)) u_ll (.a_i(a_i[HW-1:0]), .b_i(b_i[HW-1:0]), .p_o(pp_ll));
    vx_node #(.W(HW), .BLK(BLK)) u_hl (.a_i(a_i[W-1:HW]), .b_i(b_i[HW-1:0]), .p_o(pp_hl));
    vx_node #(.W(HW), .BLK(BLK)) u_lh (.a_i(a_i[HW-1:0]), .b_i(b_i[W-1:HW]), .p_o(pp_lh));
    vx_node #(.W(HW), .BLK(BLK)) u_hh (.a_i(a_i[W-1:HW]), .b_i(b_i[W-1:HW]), .p_o(pp_hh));

    // crosswise sum at weight 2^HW
    vx_csel_add #(.W(W), .BLK(BLK)) u_mid (
      .a_i(pp_hl), .b_i(pp_lh), .cin_i(1'b0), .sum_o(mid_sum), .cout_o(mid_cout)
    );

    // high*high sits directly above the upper half of low*low; the low half of low*low bypasses
    assign up_x = {pp_hh, pp_ll[W-1:HW]};
    assign up_y = UW'({mid_cout, mid_sum});

    vx_csel_add #(.W(UW), .BLK(BLK)) u_up (
      .a_i(up_x), .b_i(up_y), .cin_i(1'b0), .sum_o(up_sum), .cout_o(up_cout)
    );

    assign p_o = {up_sum, pp_ll[HW-1:0]};

    always_comb begin
      AST_NO_OVERFLOW: assert (!up_cout) else $error("merge adder overflow"); // R3
      AST_NODE_LOW: assert (p_o[HW-1:0] == HW'(a_i[HW-1:0] * b_i[HW-1:0]))
        else $error("low half wrong"); // R7
    end
  end

  always_comb begin
    AST_NODE_EXACT: assert (p_o == PW'(a_i) * PW'(b_i)) else $error("node product wrong"); // R1
  end
endmodule

// File: rtl/vx_mul16.sv
module vx_mul16 #(
  parameter int unsigned WIDTH    = 16,
  parameter int unsigned CSEL_BLK = vx_pkg::DEF_CSEL_BLK
) (
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   b_i,
  output logic [2*WIDTH-1:0] p_o
);
  vx_node #(.W(WIDTH), .BLK(CSEL_BLK)) u_root (.a_i(a_i), .b_i(b_i), .p_o(p_o));

  always_comb begin
    AST_ZERO_OPERAND: assert (!(a_i == '0 || b_i == '0) || p_o == '0)
      else $error("zero operand gave nonzero product"); // R2
  end
endmodule

// File: tb/vx_mul16_tb_top.sv
module vx_mul16_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [15:0] a16, b16;
  logic [31:0] p16;
  logic [7:0]  a8, b8;
  logic [15:0] p8;
  logic [3:0]  a4, b4;
  logic [7:0]  p4;
  logic [1:0]  a2, b2;
  logic [3:0]  p2;

  vx_mul16 dut_i (.a_i(a16), .b_i(b16), .p_o(p16));
  vx_mul16 #(.WIDTH(8)) dut_w8 (.a_i(a8), .b_i(b8), .p_o(p8));
  vx_mul16 #(.WIDTH(4)) dut_w4 (.a_i(a4), .b_i(b4), .p_o(p4));
  vx_mul16 #(.WIDTH(2)) dut_w2 (.a_i(a2), .b_i(b2), .p_o(p2));

  function automatic logic [63:0] ref_mul(logic [31:0] x, logic [31:0] y);
    return 64'(x) * 64'(y);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic drive16(logic [15:0] x, logic [15:0] y);
    @(posedge clk);
    a16 = x;
    b16 = y;
    @(negedge clk);
  endtask

  task automatic full16(string req, logic [15:0] x, logic [15:0] y);
    drive16(x, y);
    chk(req, 64'(p16), ref_mul(32'(x), 32'(y)));
    chk("R7 low half", 64'(p16[7:0]), 64'(8'(x[7:0] * y[7:0])));
  endtask

  initial begin
    a16 = '0; b16 = '0; a8 = '0; b8 = '0; a4 = '0; b4 = '0; a2 = '0; b2 = '0;
    void'($urandom(32'h1a2b3c4d));
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R2 initial zero product", 64'(p16), 64'd0);

    // R5: base cell, every pair
    for (int i = 0; i < 16; i++) begin
      @(posedge clk);
      a2 = i[3:2]; b2 = i[1:0];
      @(negedge clk);
      chk("R5 base cell", 64'(p2), ref_mul(32'(i[3:2]), 32'(i[1:0])));
    end
    // R4: exhaustive at 4 and 8 bits
    for (int i = 0; i < 256; i++) begin
      @(posedge clk);
      a4 = i[7:4]; b4 = i[3:0];
      @(negedge clk);
      chk("R4 width 4", 64'(p4), ref_mul(32'(i[7:4]), 32'(i[3:0])));
    end
    for (int i = 0; i < 65536; i++) begin
      @(posedge clk);
      a8 = i[15:8]; b8 = i[7:0];
      @(negedge clk);
      chk("R4 width 8", 64'(p8), ref_mul(32'(i[15:8]), 32'(i[7:0])));
    end

    // R2 identities
    full16("R2 zero a", 16'h0000, 16'hBEEF);
    full16("R2 zero b", 16'h1234, 16'h0000);
    drive16(16'h0001, 16'hA5C3);
    chk("R2 one a", 64'(p16), 64'h0000_A5C3);
    drive16(16'hFFFF, 16'h0001);
    chk("R2 one b", 64'(p16), 64'h0000_FFFF);
    // R3 full scale
    drive16(16'hFFFF, 16'hFFFF);
    chk("R3 max by max", 64'(p16), 64'hFFFE_0001);
    full16("R3 max by high", 16'hFFFF, 16'hFF00);
    // R6 long carry chains
    full16("R6 carry 00FF", 16'h00FF, 16'h00FF);
    full16("R6 carry 0FFF", 16'h0FFF, 16'hFFFF);
    full16("R6 carry FF00", 16'hFF00, 16'h00FF);
    full16("R6 carry 8000", 16'h8000, 16'h8000);

    // R1 constrained random, with R8 swap checks
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] x, y;
      int mode;
      mode = int'($urandom % 4);
      x = 16'($urandom);
      y = 16'($urandom);
      case (mode)
        1: begin x[15:8] = 8'h00; y[7:0] = 8'h00; end
        2: begin x = x | 16'hFF00; y = y | 16'hFF00; end
        3: begin x[7:0] = 8'hFF; y[15:8] = 8'h00; end
        default: ;
      endcase
      full16("R1 random", x, y);
      if (i % 64 == 0) begin
        drive16(y, x);
        chk("R8 swapped operands", 64'(p16), ref_mul(32'(x), 32'(y)));
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule